// File: doc/BRIEF.md
# Scanline raster-op engine

This block turns one scanline of a bit-block transfer into a stream of result words. The source stream may be misaligned with the destination by any bit count below the word width. The engine keeps the last source word it fetched and funnels it together with the next one, so each source word is fetched once. The aligned source word is combined with the matching destination word through one of the sixteen two-input boolean functions. A mask confines the change to the bits the line covers. The mask is a plane mask narrowed by partial-word masks at the two ends of the line.

A controller loads the per-line settings with a one-cycle `start` pulse. It then supplies source and destination words on two valid/ready streams and drains results from a third. For a plain copy over a word whose mask is all ones, the destination is not read at all. A one-cycle `done` pulse marks the end of the line.

Top module: `blit_line_engine`

## Requirements
- R1: Each result word equals (D AND NOT M) OR (F(S,D) AND M), where S is the aligned source word, D the destination word, M the effective mask and F the selected function. Bits outside M keep the destination value.
- R2: The 4-bit `cfg_rop` code is a truth table. Result bit = `cfg_rop[2*s + d]`, where s and d are the source and destination bits. Code 4'b1100 is plain copy, 4'b0110 is XOR and 4'b1000 is AND.
- R3: The effective mask for word 0 is `cfg_plane & cfg_first`. For the final word it is `cfg_plane & cfg_last`. For inner words it is `cfg_plane`. A one-word line uses `cfg_plane & cfg_first & cfg_last`.
- R4: With a nonzero `cfg_shift`, one source word is fetched as a primer before the first result. Output word i uses S = (P >> shift) | (N << (32 - shift)), where P is source word i and N is source word i+1. The line consumes `cfg_words + 1` source words.
- R5: With `cfg_shift` zero, there is no primer. Source word i passes unshifted as S for output i, and the line consumes `cfg_words` source words.
- R6: A destination word is requested exactly once for each output word, except when the code is 4'b1100 and that word's mask is all ones. In that case no destination word is requested and the output is S.
- R7: While `res_valid` is high and `res_ready` low, `res_valid` stays high and `res_data` does not change.
- R8: `done` is high for exactly the one cycle that follows the acceptance of the final result word.
- R9: `start` is ignored while a line is in progress and when `cfg_words` is zero. Settings are captured at the accepted `start`. While idle, `src_ready`, `dst_ready` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a line with the settings below |
| cfg_shift | input | 5 | Source-to-destination bit offset |
| cfg_rop | input | 4 | Raster function truth table |
| cfg_plane | input | 32 | Plane mask |
| cfg_first | input | 32 | Partial mask for the first word |
| cfg_last | input | 32 | Partial mask for the last word |
| cfg_words | input | 16 | Output words in the line |
| src_valid | input | 1 | Source word offered |
| src_data | input | 32 | Source word |
| src_ready | output | 1 | Engine takes a source word |
| dst_valid | input | 1 | Destination word offered |
| dst_data | input | 32 | Destination word |
| dst_ready | output | 1 | Engine takes a destination word |
| res_valid | output | 1 | Result word offered |
| res_data | output | 32 | Result word |
| res_ready | input | 1 | Consumer takes the result |
| busy | output | 1 | A line is in progress |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The hardest case to reach is one line that mixes skipped and fetched destination words. That happens in a copy whose edge masks are partial and whose inner words are unmasked. Only the edge words should be read, and each in the right order relative to the source stream. The bench builds such lines with nonzero shifts and offers exactly the expected number of destination words. An extra request would stall the line, and a missing one would leave a word unconsumed. Random back-pressure on the result stream is applied at the same time, and a second `start` is injected mid-line to show that the captured settings hold.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_FETCH = 2'd2,
    ST_EMIT  = 2'd3
  } blit_state_e;

  localparam logic [3:0] ROP_COPY = 4'b1100;
endpackage

// File: rtl/blit_align.sv
module blit_align #(
  parameter int WORD_W = 32,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] next_word,
  input  logic [SH_W-1:0]   shift,
  output logic [WORD_W-1:0] aligned
);
  logic [2*WORD_W-1:0] pair;
  logic [2*WORD_W-1:0] shifted;

  // funnel: low half of {next,prev} >> shift; shift zero bypasses (no primer)
  assign pair    = {next_word, prev_word};
  assign shifted = pair >> shift;

  always_comb begin
    if (shift == '0) aligned = next_word;
    else             aligned = shifted[WORD_W-1:0];
  end
endmodule

// File: rtl/blit_mask.sv
module blit_mask #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic [WORD_W-1:0] plane,
  input  logic [WORD_W-1:0] first_edge,
  input  logic [WORD_W-1:0] last_edge,
  input  logic [CNT_W-1:0]  idx,
  input  logic [CNT_W-1:0]  last_idx,
  output logic [WORD_W-1:0] mask
);
  logic [WORD_W-1:0] head;
  logic [WORD_W-1:0] tail;

  assign head = (idx == '0)       ? first_edge : '1;
  assign tail = (idx == last_idx) ? last_edge  : '1;
  assign mask = plane & head & tail;
endmodule

// File: rtl/blit_rop.sv
module blit_rop #(
  parameter int WORD_W = 32
) (
  input  logic [3:0]        rop,
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] func;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign func[b] = rop[{src[b], dst[b]}];
  end

  assign result = (dst & ~mask) | (func & mask);
endmodule

// File: rtl/blit_line_engine.sv
module blit_line_engine #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  localparam int SH_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SH_W-1:0]   cfg_shift,
  input  logic [3:0]        cfg_rop,
  input  logic [WORD_W-1:0] cfg_plane,
  input  logic [WORD_W-1:0] cfg_first,
  input  logic [WORD_W-1:0] cfg_last,
  input  logic [CNT_W-1:0]  cfg_words,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  output logic              src_ready,
  input  logic              dst_valid,
  input  logic [WORD_W-1:0] dst_data,
  output logic              dst_ready,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  input  logic              res_ready,
  output logic              busy,
  output logic              done
);
  import blit_pkg::*;

  blit_state_e       state_q;
  logic [SH_W-1:0]   shift_q;
  logic [3:0]        rop_q;
  logic [WORD_W-1:0] plane_q, first_q, last_q;
  logic [CNT_W-1:0]  idx_q, last_idx_q;
  logic [WORD_W-1:0] prev_q, next_q, dst_q, res_q;
  logic              have_src_q, have_dst_q, res_valid_q, done_q;

  logic [WORD_W-1:0] mask, aligned, rop_out;
  logic              need_dst, word_ready;

  blit_mask #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_mask (
    .plane(plane_q), .first_edge(first_q), .last_edge(last_q),
    .idx(idx_q), .last_idx(last_idx_q), .mask(mask)
  );

  blit_align #(.WORD_W(WORD_W)) u_align (
    .prev_word(prev_q), .next_word(next_q), .shift(shift_q), .aligned(aligned)
  );

  blit_rop #(.WORD_W(WORD_W)) u_rop (
    .rop(rop_q), .src(aligned), .dst(dst_q), .mask(mask), .result(rop_out)
  );

  assign need_dst   = !((rop_q == ROP_COPY) && (&mask));
  assign word_ready = have_src_q && (have_dst_q || !need_dst);

  assign src_ready = (state_q == ST_PRIME) || ((state_q == ST_FETCH) && !have_src_q);
  assign dst_ready = (state_q == ST_FETCH) && need_dst && !have_dst_q;
  assign res_valid = res_valid_q;
  assign res_data  = res_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      shift_q     <= '0;
      rop_q       <= '0;
      plane_q     <= '0;
      first_q     <= '0;
      last_q      <= '0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      prev_q      <= '0;
      next_q      <= '0;
      dst_q       <= '0;
      res_q       <= '0;
      have_src_q  <= 1'b0;
      have_dst_q  <= 1'b0;
      res_valid_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start && (cfg_words != '0)) begin
            shift_q    <= cfg_shift;
            rop_q      <= cfg_rop;
            plane_q    <= cfg_plane;
            first_q    <= cfg_first;
            last_q     <= cfg_last;
            idx_q      <= '0;
            last_idx_q <= cfg_words - 1'b1;
            have_src_q <= 1'b0;
            have_dst_q <= 1'b0;
            state_q    <= (cfg_shift != '0) ? ST_PRIME : ST_FETCH;
          end
        end
        ST_PRIME: begin
          if (src_valid) begin
            prev_q  <= src_data;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (src_valid && src_ready) begin
            next_q     <= src_data;
            have_src_q <= 1'b1;
          end
          if (dst_valid && dst_ready) begin
            dst_q      <= dst_data;
            have_dst_q <= 1'b1;
          end
          if (word_ready) begin
            res_q       <= rop_out;
            res_valid_q <= 1'b1;
            prev_q      <= next_q;
            have_src_q  <= 1'b0;
            have_dst_q  <= 1'b0;
            state_q     <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (res_ready) begin
            res_valid_q <= 1'b0;
            if (idx_q == last_idx_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    res_valid_q |-> (((res_q ^ dst_q) & ~mask) == '0)); // R1

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data))); // R7

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(res_valid && res_ready)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!src_ready && !dst_ready && !res_valid)); // R9
endmodule

// File: tb/blit_line_engine_bench.sv
module blit_line_engine_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  cfg_shift = '0;
  logic [3:0]  cfg_rop = '0;
  logic [31:0] cfg_plane = '0, cfg_first = '0, cfg_last = '0;
  logic [15:0] cfg_words = '0;
  logic        src_valid = 1'b0, dst_valid = 1'b0, res_ready = 1'b0;
  logic [31:0] src_data = '0, dst_data = '0;
  logic        src_ready, dst_ready, res_valid, busy, done;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int src_hs, dst_hs;
  logic [31:0] srcw[$];
  logic [31:0] dstw[$];
  logic [31:0] expq[$];

  blit_line_engine u_blit_line_engine (
    .clk(clk), .rst(rst), .start(start), .cfg_shift(cfg_shift), .cfg_rop(cfg_rop),
    .cfg_plane(cfg_plane), .cfg_first(cfg_first), .cfg_last(cfg_last),
    .cfg_words(cfg_words), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .dst_valid(dst_valid), .dst_data(dst_data),
    .dst_ready(dst_ready), .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [3:0] rop, input logic [31:0] s,
                                           input logic [31:0] d, input logic [31:0] m);
    logic [31:0] f;
    for (int b = 0; b < 32; b++) f[b] = rop[{s[b], d[b]}];
    return (d & ~m) | (f & m);
  endfunction

  task automatic feed_src();
    for (int k = 0; k < srcw.size(); k++) begin
      @(negedge clk); src_valid = 1'b1; src_data = srcw[k]; #1;
      while (!src_ready) begin @(negedge clk); #1; end
      @(posedge clk); src_hs++;
    end
    @(negedge clk); src_valid = 1'b0;
  endtask

  task automatic feed_dst();
    for (int k = 0; k < dstw.size(); k++) begin
      @(negedge clk); dst_valid = 1'b1; dst_data = dstw[k]; #1;
      while (!dst_ready) begin @(negedge clk); #1; end
      @(posedge clk); dst_hs++;
    end
    @(negedge clk); dst_valid = 1'b0;
  endtask

  task automatic monitor(input int n, input bit bp, input string tag);
    int got = 0;
    bit held = 0;
    logic [31:0] hd = '0;
    logic [31:0] e;
    while (got < n) begin
      @(negedge clk);
      res_ready = !bp || (($urandom % 3) != 0);
      #1;
      if (held) begin
        chk(res_valid && res_data == hd, "R7 hold under back-pressure", res_data, hd);
        held = 0;
      end
      if (res_valid && res_ready) begin
        e = expq.pop_front();
        chk(res_data == e, tag, res_data, e);
        got++;
      end else if (res_valid) begin
        held = 1; hd = res_data;
      end
    end
    @(negedge clk); res_ready = 1'b0; #1;
    chk(done == 1'b1, "R8 done after final accept", {31'd0, done}, 32'd1);
    @(negedge clk); #1;
    chk(done == 1'b0, "R8 done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run_line(input logic [4:0] sh, input logic [3:0] rop, input logic [31:0] pl,
                          input logic [31:0] fm, input logic [31:0] lm, input int n,
                          input bit bp, input bit inject, input string tag);
    int ns = n + ((sh != 0) ? 1 : 0);
    int di = 0;
    logic [31:0] m, s, d;
    srcw.delete(); dstw.delete(); expq.delete();
    for (int k = 0; k < ns; k++) srcw.push_back($urandom);
    for (int i = 0; i < n; i++) begin
      m = pl;
      if (i == 0) m &= fm;
      if (i == n - 1) m &= lm;
      if (sh == 0) s = srcw[i];
      else s = (srcw[i] >> sh) | (srcw[i+1] << (32 - sh));
      if (rop == 4'b1100 && m == 32'hFFFF_FFFF) d = 32'hDEAD_BEEF;
      else begin d = $urandom; dstw.push_back(d); end
      expq.push_back(ref_word(rop, s, d, m));
    end
    src_hs = 0; dst_hs = 0;
    @(negedge clk);
    cfg_shift = sh; cfg_rop = rop; cfg_plane = pl; cfg_first = fm; cfg_last = lm;
    cfg_words = 16'(n); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cfg_rop = ~rop; cfg_plane = ~pl; cfg_shift = sh + 5'd3;
    fork
      feed_src();
      feed_dst();
      monitor(n, bp, tag);
      if (inject) begin
        repeat (3) @(negedge clk);
        start = 1'b1; cfg_words = 16'd9;
        @(negedge clk); start = 1'b0;
      end
    join
    chk(src_hs == ns, (sh != 0) ? "R4 source count with primer" : "R5 source count no primer",
        32'(src_hs), 32'(ns));
    chk(dst_hs == dstw.size(), "R6 destination reads", 32'(dst_hs), 32'(dstw.size()));
    #1;
    chk(!src_ready && !dst_ready && !busy, "R9 idle after line",
        {29'd0, src_ready, dst_ready, busy}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!busy && !res_valid && !src_ready && !dst_ready && !done, "reset state",
        {27'd0, busy, res_valid, src_ready, dst_ready, done}, 32'd0);

    // R5 R6: aligned copy, full masks: no destination traffic
    run_line(5'd0, 4'b1100, '1, '1, '1, 4, 0, 0, "R5 R6 co-aligned copy");
    // R4 R6 R3: shifted copy with partial edges: only edge words read destination
    run_line(5'd5, 4'b1100, '1, 32'hFFFF_FF00, 32'h0000_0FFF, 5, 1, 0, "R4 R3 shifted copy edges");
    // R2 R1: XOR under plane mask with back-pressure
    run_line(5'd13, 4'b0110, 32'h0F0F_0F0F, 32'hFFFF_0000, 32'h0000_FFFF, 3, 1, 0, "R2 R1 xor plane");
    // R3: single word with both edges
    run_line(5'd7, 4'b1000, '1, 32'hFFFF_FFF0, 32'h0FFF_FFFF, 1, 0, 0, "R3 single word and");
    // R2: all sixteen functions at the widest shift
    for (int r = 0; r < 16; r++)
      run_line(5'd31, 4'(r), 32'hF0F0_FFFF, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 2, r[0], 0, "R2 rop sweep");
    // R9: second start mid-line is ignored
    run_line(5'd9, 4'b1110, 32'h00FF_FF00, '1, '1, 6, 1, 1, "R9 start ignored while busy");

    // R9: zero-length start ignored
    @(negedge clk); cfg_words = 16'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !src_ready && !done, "R9 zero word count ignored",
        {29'd0, busy, src_ready, done}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule